// File: doc/BRIEF.md
# Receive Character Queue with Per-Character Status

This block buffers characters that a serial receiver has already assembled. It keeps them until the processor collects them. Each accepted character goes into a data queue. In the same cycle, a companion status queue records that character's parity-error, framing-error and end-of-frame flags. The two queues move in lockstep, so a status entry always describes the data entry at the same position. The queue works the same way in every line mode.

The processor side has three controls:
- **Status strobe:** reads the status of the oldest character without removing anything.
- **Data strobe:** removes the oldest character from both queues.
- **Error-reset strobe:** clears the sticky overrun marks.

A character that arrives while every slot is in use is dropped. The newest stored character is then marked with an overrun flag, which stays set until error-reset. Depth is a parameter. Values such as 3 or 8 are typical, and the depth does not have to be a power of two.

Top module: `rx_char_queue`

## Requirements
- R1: While reset is applied and on the first cycle after it, `char_avail` and `full` are 0 and `rd_data` and `rd_stat` are 0.
- R2: When `wr_en` is high and a slot is free, the queue stores the byte and its three flags together, for any `DEPTH` of 2 or more. Characters leave in arrival order.
- R3: Suppose `rd_stat_strobe` is high while the queue holds a character. On the next cycle `rd_stat` shows the oldest entry's status: bit0 parity error, bit1 framing error, bit2 overrun, bit3 end-of-frame. The entry stays queued, and repeated reads return the same value.
- R4: Suppose `rd_data_strobe` is high while the queue holds a character. On the next cycle `rd_data` shows the oldest byte, and that entry leaves both queues. A following status read then describes the next entry.
- R5: `char_avail` is 1 exactly when at least one character is stored. `full` is 1 exactly when `DEPTH` characters are stored. Both change on the cycle after the push or pop that alters the count.
- R6: A write while the queue is full and no pop is accepted drops the incoming byte and its flags. It sets the overrun bit (status bit2) of the newest stored entry and leaves the other stored contents unchanged.
- R7: An overrun bit stays set through status reads. Only an `err_reset` pulse clears it, or the removal of its entry. If an overflow and `err_reset` fall in the same cycle, the overflow's mark is kept.
- R8: When the queue is full, a write and a data read in the same cycle both take effect. The new character is stored without an overrun mark and `full` stays 1.
- R9: A data or status read while the queue is empty changes nothing: `rd_data` and `rd_stat` keep their previous values, and no pointer moves.
- R10: When the status strobe and the data strobe arrive in the same cycle, `rd_stat` describes the entry being removed in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push one received character |
| wr_data | input | DATA_W | Received character |
| wr_par_err | input | 1 | Parity error flag of the character |
| wr_frm_err | input | 1 | Framing error flag of the character |
| wr_eof | input | 1 | End-of-frame flag of the character |
| rd_data_strobe | input | 1 | Data register read: pops both queues |
| rd_stat_strobe | input | 1 | Status register read: peeks oldest status |
| err_reset | input | 1 | Clears all overrun marks |
| rd_data | output | DATA_W | Last byte read |
| rd_stat | output | 4 | Last status read: {eof, overrun, framing, parity} |
| char_avail | output | 1 | At least one character queued |
| full | output | 1 | All DEPTH slots in use |

## Verification
Several functions can coincide in one cycle, and the bench checks each overlap:
- A write arriving at a full queue in the same cycle as a data read must be stored without an overrun mark.
- A status read alongside a data read must report the departing entry.
- An overflow alongside an error-reset must leave the new mark in place.

A three-deep instance is filled to every level from empty to full. At each level the bench applies all sixteen combinations of write, data read, status read and error-reset for one cycle, then follows with a plain status read and data read to expose the state left behind. A queue model in the bench, built from the requirements, supplies every expected value.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int FLG_W  = 3;
  localparam int STAT_W = 4;

  // Stored with every character, in lockstep with the data byte.
  typedef struct packed {
    logic eof;
    logic frm;
    logic par;
  } rx_flags_t;

  // Layout presented at the status read port.
  typedef struct packed {
    logic eof;
    logic ovr;
    logic frm;
    logic par;
  } rx_stat_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_acc,
  output logic             pop_acc,
  output logic             overflow,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] newest_ptr,
  output logic             avail_q,
  output logic             full_q
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [PTR_W-1:0] wr_q, rd_q;

  always_comb begin
    pop_acc  = pop_req && (cnt_q != '0);
    push_acc = push_req && ((cnt_q != CAP) || pop_acc);
    overflow = push_req && !push_acc;
    cnt_nxt  = cnt_q + CNT_W'(push_acc) - CNT_W'(pop_acc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
      avail_q <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      avail_q <= (cnt_nxt != '0);
      full_q  <= (cnt_nxt == CAP);
      if (push_acc) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_acc)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
    end
  end

  assign wr_ptr     = wr_q;
  assign rd_ptr     = rd_q;
  assign newest_ptr = (wr_q == '0) ? LAST : wr_q - 1'b1;

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CAP);
  // R9
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_req && cnt_q == '0) |=> $stable(rd_q));
  // R6
  overflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> (full_q && $stable(wr_q) && $stable(rd_q)));
  // R8
  full_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (push_req && pop_req && cnt_q == CAP) |=> full_q);
endmodule

// File: rtl/rxq_ram.sv
module rxq_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [PTR_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read, old contents on a same-address write.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_ovr.sv
module rxq_ovr #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [PTR_W-1:0] set_idx,
  input  logic             clr_all,
  input  logic             wipe_en,
  input  logic [PTR_W-1:0] wipe_idx,
  output logic [DEPTH-1:0] ovr_q
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                       ovr_q[i] <= 1'b0;
      else if (set_en && set_idx == PTR_W'(i))       ovr_q[i] <= 1'b1;
      else if (clr_all)                              ovr_q[i] <= 1'b0;
      else if (wipe_en && wipe_idx == PTR_W'(i))     ovr_q[i] <= 1'b0;
    end
  end

  // R6
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ovr_q[$past(set_idx)]);
  // R7
  ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_all && !set_en) |=> (ovr_q == '0));
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_par_err,
  input  logic              wr_frm_err,
  input  logic              wr_eof,
  input  logic              rd_data_strobe,
  input  logic              rd_stat_strobe,
  input  logic              err_reset,
  output logic [DATA_W-1:0] rd_data,
  output logic [3:0]        rd_stat,
  output logic              char_avail,
  output logic              full
);
  import rxq_pkg::*;

  logic             push_acc, pop_acc, overflow, stat_acc;
  logic [PTR_W-1:0] wr_ptr, rd_ptr, newest_ptr;
  logic [DEPTH-1:0] ovr_bits;
  logic             ovr_rd_q;
  rx_flags_t        flg_in, flg_out;
  rx_stat_t         stat_view;

  assign flg_in   = '{eof: wr_eof, frm: wr_frm_err, par: wr_par_err};
  assign stat_acc = rd_stat_strobe && char_avail;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .push_req(wr_en), .pop_req(rd_data_strobe),
    .push_acc(push_acc), .pop_acc(pop_acc), .overflow(overflow),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .newest_ptr(newest_ptr),
    .avail_q(char_avail), .full_q(full)
  );

  rxq_ram #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_data_q (
    .clk(clk), .rst(rst),
    .we(push_acc), .waddr(wr_ptr), .wdata(wr_data),
    .re(pop_acc), .raddr(rd_ptr), .rdata(rd_data)
  );

  rxq_ram #(.DEPTH(DEPTH), .WIDTH(FLG_W)) u_stat_q (
    .clk(clk), .rst(rst),
    .we(push_acc), .waddr(wr_ptr), .wdata(flg_in),
    .re(stat_acc), .raddr(rd_ptr), .rdata(flg_out)
  );

  rxq_ovr #(.DEPTH(DEPTH)) u_ovr (
    .clk(clk), .rst(rst),
    .set_en(overflow), .set_idx(newest_ptr),
    .clr_all(err_reset),
    .wipe_en(push_acc), .wipe_idx(wr_ptr),
    .ovr_q(ovr_bits)
  );

  always_ff @(posedge clk) begin
    if (rst)           ovr_rd_q <= 1'b0;
    else if (stat_acc) ovr_rd_q <= ovr_bits[rd_ptr];
  end

  assign stat_view = '{eof: flg_out.eof, ovr: ovr_rd_q, frm: flg_out.frm, par: flg_out.par};
  assign rd_stat   = stat_view;

  // R9
  idle_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_data_strobe && char_avail) |=> $stable(rd_data));
  // R9
  idle_stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_stat_strobe && char_avail) |=> $stable(rd_stat));
  // R3
  peek_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stat_strobe && !rd_data_strobe && !wr_en && char_avail) |=> char_avail);
  // R5
  full_implies_avail_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> char_avail);
endmodule

// File: tb/tb_rx_char_queue.sv
`timescale 1ns/1ps
module tb_rx_char_queue;
  localparam int DEPTH = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 0, wr_par_err = 0, wr_frm_err = 0, wr_eof = 0;
  logic [7:0] wr_data = '0;
  logic       rd_data_strobe = 0, rd_stat_strobe = 0, err_reset = 0;
  logic [7:0] rd_data;
  logic [3:0] rd_stat;
  logic       char_avail, full;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [11:0] mq[$];   // [7:0] data, [8] par, [9] frm, [10] eof, [11] overrun
  logic [7:0]  exp_data = '0;
  logic [3:0]  exp_stat = '0;
  int          pat = 0;

  always #4 clk = ~clk;

  rx_char_queue #(.DEPTH(DEPTH), .DATA_W(8)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_par_err(wr_par_err), .wr_frm_err(wr_frm_err), .wr_eof(wr_eof),
    .rd_data_strobe(rd_data_strobe), .rd_stat_strobe(rd_stat_strobe),
    .err_reset(err_reset), .rd_data(rd_data), .rd_stat(rd_stat),
    .char_avail(char_avail), .full(full)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit w, input logic [7:0] d, input logic [2:0] f,
                      input bit p, input bit k, input bit e, input string tag);
    int n;
    bit pa, acc, ov;
    wr_en = w; wr_data = d; {wr_eof, wr_frm_err, wr_par_err} = f;
    rd_data_strobe = p; rd_stat_strobe = k; err_reset = e;
    @(posedge clk);
    n   = mq.size();
    pa  = p && (n > 0);
    acc = w && ((n < DEPTH) || pa);
    ov  = w && !acc;
    if (k && n > 0) exp_stat = {mq[0][10], mq[0][11], mq[0][9], mq[0][8]};
    if (pa) exp_data = mq[0][7:0];
    if (e) foreach (mq[i]) mq[i][11] = 1'b0;
    if (ov) mq[n-1][11] = 1'b1;
    if (pa) void'(mq.pop_front());
    if (acc) mq.push_back({1'b0, f, d});
    @(negedge clk);
    wr_en = 0; rd_data_strobe = 0; rd_stat_strobe = 0; err_reset = 0;
    check(tag, "rd_data", rd_data, exp_data);
    check(tag, "rd_stat", rd_stat, exp_stat);
    check("R5", "char_avail", char_avail, mq.size() != 0);
    check("R5", "full", full, mq.size() == DEPTH);
  endtask

  task automatic push_next(input string tag);
    logic [7:0] d;
    logic [2:0] f;
    pat++;
    d = 8'(pat * 29 + 7);
    f = 3'(pat) ^ 3'(pat >> 3);
    step(1, d, f, 0, 0, 0, tag);
  endtask

  function automatic string tag_for(input int fill, input int op);
    bit w, p, k, e;
    {e, k, p, w} = 4'(op);
    if (fill == DEPTH && w && !p) return "R6";
    if (fill == DEPTH && w && p)  return "R8";
    if (fill == 0 && (p || k))    return "R9";
    if (p && k)                   return "R10";
    if (e)                        return "R7";
    if (k)                        return "R3";
    if (p)                        return "R4";
    return "R2";
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs while reset still applied
    check("R1", "char_avail", char_avail, 0);
    check("R1", "full", full, 0);
    check("R1", "rd_data", rd_data, 0);
    check("R1", "rd_stat", rd_stat, 0);
    rst = 0;
    step(0, 8'h00, 3'b000, 0, 0, 0, "R1");

    // Sweep every fill level against every strobe combination.
    for (int fill = 0; fill <= DEPTH; fill++) begin
      for (int op = 0; op < 16; op++) begin
        while (mq.size() > 0) step(0, 8'h00, 3'b000, 1, 0, 0, "R4");
        step(0, 8'h00, 3'b000, 0, 0, 1, "R7");
        for (int j = 0; j < fill; j++) push_next("R2");
        pat++;
        step(op[0], 8'(pat * 53 + 11), 3'(pat), op[1], op[2], op[3], tag_for(fill, op));
        step(0, 8'h00, 3'b000, 0, 1, 0, "R3");
        step(0, 8'h00, 3'b000, 1, 0, 0, "R4");
        step(0, 8'h00, 3'b000, 0, 1, 0, "R3");
      end
    end

    // Sticky overrun walks to the head and survives peeks until error-reset.
    while (mq.size() > 0) step(0, 8'h00, 3'b000, 1, 0, 0, "R4");
    for (int j = 0; j < DEPTH; j++) push_next("R2");
    step(1, 8'hEE, 3'b111, 0, 0, 0, "R6");
    step(0, 8'h00, 3'b000, 0, 1, 0, "R6");
    for (int j = 0; j < DEPTH - 1; j++) step(0, 8'h00, 3'b000, 1, 0, 0, "R4");
    step(0, 8'h00, 3'b000, 0, 1, 0, "R7");
    step(0, 8'h00, 3'b000, 0, 1, 0, "R7");
    check("R7", "overrun bit", rd_stat[2], 1);
    step(0, 8'h00, 3'b000, 0, 0, 1, "R7");
    step(0, 8'h00, 3'b000, 0, 1, 0, "R7");
    check("R7", "overrun after reset", rd_stat[2], 0);
    // Overflow and error-reset together: mark kept.
    for (int j = 0; j < DEPTH - 1; j++) push_next("R2");
    step(1, 8'h5A, 3'b010, 0, 0, 1, "R7");
    for (int j = 0; j < DEPTH - 1; j++) step(0, 8'h00, 3'b000, 1, 0, 0, "R4");
    step(0, 8'h00, 3'b000, 1, 1, 0, "R10");
    check("R7", "overrun kept over reset", rd_stat[2], 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all-R actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule